// File: doc/BRIEF.md
# Integer ALU Execute Unit

This block is the execute stage of a small RISC-style integer core. Each cycle it may accept one already-decoded operation: a 5-bit operation code, up to three register indices and a 16-bit immediate. It reads its operands from an internal 32-entry by 32-bit register file. It computes a moves, add, subtract, reverse-subtract, bitwise logic or immediate result, and writes that result back on the next clock edge. At the same edge it raises a one-cycle result pulse that carries the destination index and the value written.

Register operands use two roles. `idx_a` names the first source (reg1). For two-operand and short-immediate forms, `idx_b` names the register that is both the second source and the destination (reg2). The three-operand immediate forms read `idx_a` and write `idx_c`. Short-immediate forms use `imm[4:0]` and ignore `imm[15:5]`. Because the write lands at the same edge that raises the result pulse, an operation issued in the next cycle already reads the new value.

The block produces no condition or status flags. Sums and differences wrap modulo 2^32.

Top module: `int_exec_unit`

## Requirements
- R1: A synchronous active-high `rst` clears every register to zero and holds `res_valid` low.
- R2: When `op_valid` is high with a legal code, the clock edge that samples it writes the destination register. `res_valid` is high for exactly the following cycle, with `res_idx` equal to the destination and `res_data` equal to the result. An operation issued in the next cycle reads the updated value.
- R3: Register moves and arithmetic: code 0 writes reg1 into reg2, code 2 writes reg2+reg1, code 3 writes reg2-reg1, and code 4 writes reg1-reg2. The destination is `idx_b`.
- R4: Register logic: code 5 writes reg2 AND reg1, code 6 writes reg2 OR reg1, code 7 writes reg2 XOR reg1, and code 1 writes NOT reg1. The destination is `idx_b`.
- R5: Short immediate: `imm[4:0]` is sign-extended to 32 bits. Code 8 writes it into reg2 and code 9 adds it to reg2. The destination is `idx_b`, and `imm[15:5]` has no effect.
- R6: Code 10 and code 11 each sign-extend `imm[15:0]`, add it to register `idx_a`, and write the sum to `idx_c`.
- R7: Code 12 forms `{imm, 16'h0000}`, adds it to register `idx_a`, and writes the sum to `idx_c`. The low 16 bits of the result therefore equal those of the source.
- R8: Codes 13 (AND), 14 (OR) and 15 (XOR) zero-extend `imm[15:0]`, combine it with register `idx_a`, and write the result to `idx_c`.
- R9: Addition and subtraction wrap modulo 2^32 with no trap or flag.
- R10: Register index 0 always reads as zero. A write aimed at it is discarded, but it still produces a result pulse with `res_idx` = 0 and the computed value on `res_data`.
- R11: Codes 16 to 31, or `op_valid` low, write nothing and raise no `res_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 5 | Operation code |
| idx_a | input | 5 | First source register index (reg1) |
| idx_b | input | 5 | Second source and two-operand destination index (reg2) |
| idx_c | input | 5 | Destination index for three-operand immediate forms |
| imm | input | 16 | Immediate field |
| res_valid | output | 1 | One-cycle pulse: a result was written |
| res_idx | output | 5 | Destination index of the result |
| res_data | output | 32 | Value of the result |

## Verification
The bench builds the block with its default parameters: 32-bit data, 32 registers, a 16-bit immediate and a 5-bit short immediate. At these values the index range covers both register 0 and register 31. The sign bits sit at bits 4 and 15 of the immediate, so the bench can pick patterns such as 0x10, 0x8000 and 0xFFFF that separate sign extension from zero extension. The upper-half placement of code 12 lands exactly on bits 31:16, so carries between the halves and wrap at 2^32 can be provoked with a few chosen values before a long randomized run.

// File: rtl/iexu_pkg.sv
package iexu_pkg;

  typedef enum logic [4:0] {
    OP_MOV   = 5'd0,
    OP_NOT   = 5'd1,
    OP_ADD   = 5'd2,
    OP_SUB   = 5'd3,
    OP_SUBR  = 5'd4,
    OP_AND   = 5'd5,
    OP_OR    = 5'd6,
    OP_XOR   = 5'd7,
    OP_MOVS  = 5'd8,
    OP_ADDS  = 5'd9,
    OP_ADDI  = 5'd10,
    OP_MOVEA = 5'd11,
    OP_MOVHI = 5'd12,
    OP_ANDI  = 5'd13,
    OP_ORI   = 5'd14,
    OP_XORI  = 5'd15
  } op_e;

  localparam int OP_W = 5;

  // Codes at or above this value are reserved (R11)
  localparam logic [OP_W-1:0] OP_FIRST_RESERVED = 5'd16;

  function automatic logic op_is_legal(input logic [OP_W-1:0] code);
    return code < OP_FIRST_RESERVED;
  endfunction

  // Three-operand immediate forms write the third index
  function automatic logic op_uses_third(input logic [OP_W-1:0] code);
    return code >= OP_ADDI && code <= OP_XORI;
  endfunction

endpackage

// File: rtl/iexu_regfile.sv
module iexu_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] ra_idx,
  output logic [DW-1:0] ra_data,
  input  logic [IW-1:0] rb_idx,
  output logic [DW-1:0] rb_data,
  input  logic          we,
  input  logic [IW-1:0] wa_idx,
  input  logic [DW-1:0] wa_data
);

  logic [DW-1:0]   bank [NREG];
  logic [NREG-1:0] wen;

  // Per-entry write enables; entry 0 never gets one
  for (genvar g = 0; g < NREG; g++) begin : g_wdec
    if (g == 0) begin : g_zero
      assign wen[g] = 1'b0;
    end else begin : g_live
      assign wen[g] = we && (wa_idx == IW'(g));
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (rst)          bank[i] <= '0;
      else if (wen[i])  bank[i] <= wa_data;
    end
  end

  assign ra_data = (ra_idx == '0) ? '0 : bank[ra_idx];
  assign rb_data = (rb_idx == '0) ? '0 : bank[rb_idx];

endmodule

// File: rtl/iexu_immgen.sv
module iexu_immgen #(
  parameter int DW     = 32,
  parameter int IMM_W  = 16,
  parameter int SIMM_W = 5
) (
  input  logic [IMM_W-1:0] imm,
  output logic [DW-1:0]    short_sx,
  output logic [DW-1:0]    long_sx,
  output logic [DW-1:0]    long_zx,
  output logic [DW-1:0]    long_hi
);

  localparam int HI_SH = DW - IMM_W;

  function automatic logic [DW-1:0] sext_short(input logic [SIMM_W-1:0] v);
    return {{(DW-SIMM_W){v[SIMM_W-1]}}, v};
  endfunction

  function automatic logic [DW-1:0] sext_long(input logic [IMM_W-1:0] v);
    return {{(DW-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [DW-1:0] zext_long(input logic [IMM_W-1:0] v);
    return {{(DW-IMM_W){1'b0}}, v};
  endfunction

  function automatic logic [DW-1:0] upper_place(input logic [IMM_W-1:0] v);
    return zext_long(v) << HI_SH;
  endfunction

  assign short_sx = sext_short(imm[SIMM_W-1:0]);
  assign long_sx  = sext_long(imm);
  assign long_zx  = zext_long(imm);
  assign long_hi  = upper_place(imm);

endmodule

// File: rtl/iexu_datapath.sv
module iexu_datapath
  import iexu_pkg::*;
#(
  parameter int DW = 32,
  parameter int IW = 5
) (
  input  logic [OP_W-1:0] op,
  input  logic [DW-1:0]   reg1,
  input  logic [DW-1:0]   reg2,
  input  logic [DW-1:0]   short_sx,
  input  logic [DW-1:0]   long_sx,
  input  logic [DW-1:0]   long_zx,
  input  logic [DW-1:0]   long_hi,
  input  logic [IW-1:0]   idx_b,
  input  logic [IW-1:0]   idx_c,
  output logic [DW-1:0]   result,
  output logic [IW-1:0]   dst,
  output logic            legal
);

  // Wrapping arithmetic, no carry out kept
  function automatic logic [DW-1:0] wrap_add(input logic [DW-1:0] x, input logic [DW-1:0] y);
    return x + y;
  endfunction

  function automatic logic [DW-1:0] wrap_sub(input logic [DW-1:0] x, input logic [DW-1:0] y);
    return x - y;
  endfunction

  assign legal = op_is_legal(op);
  assign dst   = op_uses_third(op) ? idx_c : idx_b;

  always_comb begin
    result = '0;
    case (op)
      OP_MOV:   result = reg1;
      OP_NOT:   result = ~reg1;
      OP_ADD:   result = wrap_add(reg2, reg1);
      OP_SUB:   result = wrap_sub(reg2, reg1);
      OP_SUBR:  result = wrap_sub(reg1, reg2);
      OP_AND:   result = reg2 & reg1;
      OP_OR:    result = reg2 | reg1;
      OP_XOR:   result = reg2 ^ reg1;
      OP_MOVS:  result = short_sx;
      OP_ADDS:  result = wrap_add(reg2, short_sx);
      OP_ADDI,
      OP_MOVEA: result = wrap_add(reg1, long_sx);
      OP_MOVHI: result = wrap_add(reg1, long_hi);
      OP_ANDI:  result = reg1 & long_zx;
      OP_ORI:   result = reg1 | long_zx;
      OP_XORI:  result = reg1 ^ long_zx;
      default:  result = '0;
    endcase
  end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import iexu_pkg::*;
#(
  parameter int DW     = 32,
  parameter int NREG   = 32,
  parameter int IMM_W  = 16,
  parameter int SIMM_W = 5,
  localparam int IW    = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [OP_W-1:0]  op_sel,
  input  logic [IW-1:0]    idx_a,
  input  logic [IW-1:0]    idx_b,
  input  logic [IW-1:0]    idx_c,
  input  logic [IMM_W-1:0] imm,
  output logic             res_valid,
  output logic [IW-1:0]    res_idx,
  output logic [DW-1:0]    res_data
);

  logic [DW-1:0] rd_a, rd_b;
  logic [DW-1:0] short_sx, long_sx, long_zx, long_hi;
  logic [DW-1:0] alu_out;
  logic [IW-1:0] alu_dst;
  logic          op_legal;
  logic          wr_en;

  assign wr_en = op_valid && op_legal;

  iexu_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .ra_idx  (idx_a),
    .ra_data (rd_a),
    .rb_idx  (idx_b),
    .rb_data (rd_b),
    .we      (wr_en),
    .wa_idx  (alu_dst),
    .wa_data (alu_out)
  );

  iexu_immgen #(.DW(DW), .IMM_W(IMM_W), .SIMM_W(SIMM_W)) u_imm (
    .imm      (imm),
    .short_sx (short_sx),
    .long_sx  (long_sx),
    .long_zx  (long_zx),
    .long_hi  (long_hi)
  );

  iexu_datapath #(.DW(DW), .IW(IW)) u_dp (
    .op       (op_sel),
    .reg1     (rd_a),
    .reg2     (rd_b),
    .short_sx (short_sx),
    .long_sx  (long_sx),
    .long_zx  (long_zx),
    .long_hi  (long_hi),
    .idx_b    (idx_b),
    .idx_c    (idx_c),
    .result   (alu_out),
    .dst      (alu_dst),
    .legal    (op_legal)
  );

  // Result report, aligned with the register-file write
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_idx   <= '0;
      res_data  <= '0;
    end else begin
      res_valid <= wr_en;
      if (wr_en) begin
        res_idx  <= alu_dst;
        res_data <= alu_out;
      end
    end
  end

endmodule

// File: rtl/iexu_checker.sv
module iexu_checker
  import iexu_pkg::*;
#(
  parameter int DW     = 32,
  parameter int IW     = 5,
  parameter int IMM_W  = 16,
  parameter int SIMM_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             op_valid,
  input logic [OP_W-1:0]  op_sel,
  input logic [IW-1:0]    idx_a,
  input logic [IW-1:0]    idx_b,
  input logic [IW-1:0]    idx_c,
  input logic [IMM_W-1:0] imm,
  input logic             res_valid,
  input logic [IW-1:0]    res_idx,
  input logic [DW-1:0]    res_data,
  input logic [DW-1:0]    rd_a
);

  localparam int HALF = DW - IMM_W;

  AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel < 5'd16) |=> res_valid); // R2

  AST_DEST_ECHO: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel < 5'd10) |=> res_idx == $past(idx_b)); // R2

  AST_THIRD_DEST_ECHO: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel >= 5'd10 && op_sel < 5'd16) |=> res_idx == $past(idx_c)); // R6

  AST_NO_RESULT_RESERVED: assert property (@(posedge clk) disable iff (rst)
    !(op_valid && op_sel < 5'd16) |=> !res_valid); // R11

  AST_ZERO_INDEX_READ: assert property (@(posedge clk) disable iff (rst)
    (idx_a == '0) |-> rd_a == '0); // R10

  AST_SHORT_MOVE_SEXT: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == 5'd8) |=>
      res_data == {{(DW-SIMM_W){$past(imm[SIMM_W-1])}}, $past(imm[SIMM_W-1:0])}); // R5

  AST_UPPER_ADD_LOW_HALF: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == 5'd12) |=> res_data[HALF-1:0] == $past(rd_a[HALF-1:0])); // R7

  AST_AND_IMM_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == 5'd13) |=> res_data[DW-1:IMM_W] == '0); // R8

endmodule

bind int_exec_unit iexu_checker #(
  .DW(DW), .IW(IW), .IMM_W(IMM_W), .SIMM_W(SIMM_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_valid  (op_valid),
  .op_sel    (op_sel),
  .idx_a     (idx_a),
  .idx_b     (idx_b),
  .idx_c     (idx_c),
  .imm       (imm),
  .res_valid (res_valid),
  .res_idx   (res_idx),
  .res_data  (res_data),
  .rd_a      (rd_a)
);

// File: tb/int_exec_unit_bench.sv
module int_exec_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [4:0]  op_sel = '0;
  logic [4:0]  idx_a = '0, idx_b = '0, idx_c = '0;
  logic [15:0] imm = '0;
  logic        res_valid;
  logic [4:0]  res_idx;
  logic [31:0] res_data;

  always #4 clk = ~clk; // 125 MHz

  int_exec_unit u_int_exec_unit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
    .idx_a(idx_a), .idx_b(idx_b), .idx_c(idx_c), .imm(imm),
    .res_valid(res_valid), .res_idx(res_idx), .res_data(res_data)
  );

  typedef struct {
    logic [4:0]  idx;
    logic [31:0] data;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] mdl [32];
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [4:0] i);
    return (i == 5'd0) ? 32'h0 : mdl[i];
  endfunction

  // Reference: extensions done by arithmetic shifts, not concatenation
  function automatic logic [31:0] s5(input logic [15:0] v);
    logic signed [31:0] t;
    t = {v[4:0], 27'd0};
    return t >>> 27;
  endfunction

  function automatic logic [31:0] s16(input logic [15:0] v);
    logic signed [31:0] t;
    t = {v, 16'd0};
    return t >>> 16;
  endfunction

  task automatic issue(input logic [4:0] op, input logic [4:0] a, input logic [4:0] b,
                       input logic [4:0] c, input logic [15:0] im, input string tag);
    logic [31:0] r1, r2, e;
    logic [4:0]  d;
    exp_t        it;
    @(negedge clk);
    op_valid = 1'b1; op_sel = op; idx_a = a; idx_b = b; idx_c = c; imm = im;
    r1 = rd(a); r2 = rd(b); d = b; e = '0;
    case (op)
      5'd0:  e = r1;
      5'd1:  e = ~r1;
      5'd2:  e = r1 + r2;
      5'd3:  e = r2 - r1;
      5'd4:  e = r1 - r2;
      5'd5:  e = r1 & r2;
      5'd6:  e = r1 | r2;
      5'd7:  e = r1 ^ r2;
      5'd8:  e = s5(im);
      5'd9:  e = r2 + s5(im);
      5'd10, 5'd11: begin d = c; e = r1 + s16(im); end
      5'd12: begin d = c; e = r1 + (32'(im) * 32'h10000); end
      5'd13: begin d = c; e = r1 & 32'(im); end
      5'd14: begin d = c; e = r1 | 32'(im); end
      5'd15: begin d = c; e = r1 ^ 32'(im); end
      default: ;
    endcase
    if (op < 5'd16) begin
      it.idx = d; it.data = e; it.tag = tag;
      sb.push_back(it);
      if (d != 5'd0) mdl[d] = e;
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      op_valid = 1'b0;
    end
  endtask

  // Monitor: pop and compare every reported result
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && res_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R11", "unexpected result", res_data, 32'h0);
        end else begin
          exp_t it;
          it = sb.pop_front();
          check(res_idx == it.idx, it.tag, "res_idx", 32'(res_idx), 32'(it.idx));
          check(res_data == it.data, it.tag, "res_data", res_data, it.data);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    // Preload garbage into bench-visible inputs during reset
    repeat (3) @(negedge clk);
    op_valid = 1'b1; op_sel = 5'd8; idx_b = 5'd3; imm = 16'h0005;
    @(negedge clk);
    rst = 1'b0; op_valid = 1'b0;
    @(negedge clk);
    check(res_valid == 1'b0, "R1", "res_valid after reset", 32'(res_valid), 32'h0);

    // R1: registers read back zero
    issue(5'd10, 5'd3, 5'd0, 5'd20, 16'h0000, "R1");
    issue(5'd10, 5'd31, 5'd0, 5'd21, 16'h0000, "R1");
    idle(1);

    // R5: short immediate sign extension, upper imm bits ignored
    issue(5'd8, 5'd0, 5'd1, 5'd0, 16'h001F, "R5");
    issue(5'd8, 5'd0, 5'd2, 5'd0, 16'hFFEF, "R5");
    issue(5'd8, 5'd0, 5'd3, 5'd0, 16'hABF0, "R5");
    issue(5'd9, 5'd0, 5'd2, 5'd0, 16'h001F, "R5");
    // R7 / R6: upper placement and sign-extended 16-bit adds
    issue(5'd12, 5'd0, 5'd0, 5'd4, 16'h1234, "R7");
    issue(5'd10, 5'd4, 5'd0, 5'd5, 16'h8000, "R6");
    issue(5'd11, 5'd4, 5'd0, 5'd6, 16'h7FFF, "R6");
    issue(5'd12, 5'd1, 5'd0, 5'd7, 16'hFFFF, "R7");
    // R8: zero-extended logical immediates
    issue(5'd13, 5'd1, 5'd0, 5'd8, 16'h8001, "R8");
    issue(5'd14, 5'd4, 5'd0, 5'd9, 16'hF00F, "R8");
    issue(5'd15, 5'd1, 5'd0, 5'd10, 16'hFFFF, "R8");
    // R3: moves, add, both subtraction orders (back-to-back, R2)
    issue(5'd0, 5'd5, 5'd11, 5'd0, 16'h0, "R3");
    issue(5'd2, 5'd2, 5'd11, 5'd0, 16'h0, "R3");
    issue(5'd3, 5'd4, 5'd11, 5'd0, 16'h0, "R3");
    issue(5'd4, 5'd2, 5'd11, 5'd0, 16'h0, "R3");
    // R4: logic and complement
    issue(5'd5, 5'd9, 5'd11, 5'd0, 16'h0, "R4");
    issue(5'd6, 5'd8, 5'd11, 5'd0, 16'h0, "R4");
    issue(5'd7, 5'd1, 5'd11, 5'd0, 16'h0, "R4");
    issue(5'd1, 5'd11, 5'd12, 5'd0, 16'h0, "R4");
    // R9: wrap at 2^32
    issue(5'd8, 5'd0, 5'd13, 5'd0, 16'h0001, "R9");
    issue(5'd2, 5'd1, 5'd13, 5'd0, 16'h0, "R9");
    issue(5'd3, 5'd1, 5'd14, 5'd0, 16'h0, "R9");
    issue(5'd12, 5'd7, 5'd0, 5'd15, 16'h0002, "R9");
    idle(1);
    // R10: register 0 ignores writes and reads zero
    issue(5'd8, 5'd0, 5'd0, 5'd0, 16'h0007, "R10");
    issue(5'd10, 5'd0, 5'd0, 5'd16, 16'h0000, "R10");
    issue(5'd2, 5'd0, 5'd2, 5'd0, 16'h0, "R10");
    idle(1);
    // R11: reserved code and idle cycle leave r2 alone
    issue(5'd17, 5'd1, 5'd2, 5'd2, 16'h1111, "R11");
    @(negedge clk);
    check(res_valid == 1'b0, "R11", "res_valid after reserved code", 32'(res_valid), 32'h0);
    op_valid = 1'b0; op_sel = 5'd8; idx_b = 5'd2; imm = 16'h0003;
    @(negedge clk);
    check(res_valid == 1'b0, "R11", "res_valid while idle", 32'(res_valid), 32'h0);
    issue(5'd10, 5'd2, 5'd0, 5'd17, 16'h0000, "R11");
    idle(2);

    // R2: long randomized stream checked by the scoreboard
    for (int n = 0; n < 400; n++) begin
      logic [31:0] rv;
      rv = $urandom;
      issue(5'(rv[3:0]), 5'(rv[8:4]), 5'(rv[13:9]), 5'(rv[18:14]), 16'($urandom), "R2");
      if (rv[31:29] == 3'd0) idle(1);
    end
    idle(4);
    check(sb.size() == 0, "R2", "scoreboard drained", 32'(sb.size()), 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 20000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule